// File: doc/BRIEF.md
# Priority-Weighted Queue Class Scheduler

This block decides which of three traffic-class queues owns a shared egress next. Class 0 carries latency-critical traffic, class 1 is a balanced class and class 2 is a bulk class. Each queue raises a request and offers a packet length in beats. The scheduler answers with a one-hot grant, keeps that grant on one queue for the whole packet, and keeps a saturating count of the packets started by each class.

The latency class wins every decision until it has used its per-window allowance. The balanced and bulk classes share the remaining decisions in a 2:4 weighted pattern, and bulk loses its turn once it reaches its per-window cap while another class is waiting. A window is 64 packet starts; all window accounting restarts after the 64th. A class that requests alone is never held back by any cap.

The egress side works like a valid/ready stream. The grant is the valid side and `out_ready` is the ready side. A beat moves only in a cycle where both are high. While `out_ready` is low, nothing advances. The grant shown may come from a pending decision, and it becomes binding in the first cycle it is accepted. A requesting queue must keep its request high until the last beat of its packet has been accepted.

Top module: `qos_class_sched`

## Requirements
- R1: `grant` has at most one bit set. While no packet is in progress, `grant` is a subset of `req`, and it is zero when `req` is zero. Bit 0 is the latency class, bit 1 the balanced class, bit 2 the bulk class.
- R2: A packet starts in a cycle where the grant is non-zero, no packet is in progress and `out_ready` is high. The grant then stays on that class until L beats have been accepted, where L is that class's `len_hint` slice (class i uses bits i*LEN_W upward; a value of 0 counts as 1). Cycles with `out_ready` low accept nothing and change nothing.
- R3: When exactly one class requests, it is granted, whatever the caps and weights say.
- R4: The latency class wins a decision whenever it requests and its starts in the current window are below `cfg_pri_max`.
- R5: Once the latency class has reached `cfg_pri_max` starts in the window, other requesting classes are served ahead of it.
- R6: When balanced and bulk contend and both are eligible, decisions follow the repeating order balanced, balanced, bulk, bulk, bulk, bulk. The weight credits are consumed only by such contended decisions.
- R7: Once bulk has reached `cfg_bulk_cap` starts in the window and another class requests, bulk is not granted.
- R8: If every requesting class is over its cap, the latency class is granted if it requests; otherwise bulk is granted.
- R9: After 64 packet starts, the latency usage, the bulk usage and the weight credits all return to their reset values.
- R10: `svc_count` slice i (bits i*CNT_W upward) counts the packet starts of class i, once per packet, and saturates at all ones.
- R11: After reset, all counts are zero, and the grant is zero while there are no requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 3 | Per-class request: bit 0 latency, bit 1 balanced, bit 2 bulk |
| len_hint | input | 3*LEN_W | Per-class packet length in beats |
| out_ready | input | 1 | Egress accepts a beat this cycle |
| cfg_pri_max | input | 7 | Latency-class starts allowed per window |
| cfg_bulk_cap | input | 7 | Bulk-class starts allowed per window under contention |
| grant | output | 3 | One-hot owner of the egress |
| svc_count | output | 3*CNT_W | Saturating per-class packet-start counters |

## Verification
The assertions assume that a class holding the grant keeps its request high until its last beat is accepted. They also assume that the two cap inputs only change while the block is idle. The bench follows both rules: every packet it starts keeps its request until the final beat, and it changes the caps only during reset. With those inputs, it drives single-beat weighted mixes from a vector table. It then runs directed sequences for cap exhaustion, the window rollover, back-pressure during a multi-beat packet and counter saturation with a narrowed counter.

// File: rtl/qsched_pkg.sv
package qsched_pkg;
  localparam int NUM_CLS  = 3;
  localparam int CLS_LAT  = 0;
  localparam int CLS_BAL  = 1;
  localparam int CLS_BULK = 2;
  localparam int DEF_W_BAL  = 2;
  localparam int DEF_W_BULK = 4;
endpackage

// File: rtl/qsched_pick.sv
module qsched_pick #(
  parameter int WIN_W  = 6,
  parameter int CRED_W = 3,
  parameter int W_BAL  = 2,
  parameter int W_BULK = 4
) (
  input  logic [2:0]        req,
  input  logic [WIN_W:0]    pri_used,
  input  logic [WIN_W:0]    bulk_used,
  input  logic [WIN_W:0]    cfg_pri_max,
  input  logic [WIN_W:0]    cfg_bulk_cap,
  input  logic [CRED_W-1:0] bal_cred,
  input  logic [CRED_W-1:0] bulk_cred,
  output logic [2:0]        pick,
  output logic [CRED_W-1:0] bal_cred_nx,
  output logic [CRED_W-1:0] bulk_cred_nx
);
  import qsched_pkg::*;

  logic sole, lat_ok, bal_ok, bulk_ok, reload;
  logic [CRED_W-1:0] eff_bal, eff_bulk;

  always_comb begin
    sole     = ($countones(req) == 1);
    lat_ok   = req[CLS_LAT]  && (sole || (pri_used  < cfg_pri_max));
    bulk_ok  = req[CLS_BULK] && (sole || (bulk_used < cfg_bulk_cap));
    bal_ok   = req[CLS_BAL];
    reload   = (bal_cred == '0) && (bulk_cred == '0);
    eff_bal  = reload ? CRED_W'(W_BAL)  : bal_cred;
    eff_bulk = reload ? CRED_W'(W_BULK) : bulk_cred;

    pick         = 3'b000;
    bal_cred_nx  = bal_cred;
    bulk_cred_nx = bulk_cred;
    if (lat_ok) begin
      pick = 3'b001;
    end else if (bal_ok && bulk_ok) begin
      if (eff_bal != '0) begin
        pick         = 3'b010;
        bal_cred_nx  = eff_bal - 1'b1;
        bulk_cred_nx = eff_bulk;
      end else begin
        pick         = 3'b100;
        bal_cred_nx  = eff_bal;
        bulk_cred_nx = eff_bulk - 1'b1;
      end
    end else if (bal_ok) begin
      pick = 3'b010;
    end else if (bulk_ok) begin
      pick = 3'b100;
    end else if (req[CLS_LAT]) begin
      pick = 3'b001;
    end else if (req[CLS_BULK]) begin
      pick = 3'b100;
    end
  end
endmodule

// File: rtl/qsched_window.sv
module qsched_window #(
  parameter int WIN_SLOTS = 64,
  parameter int CRED_W    = 3,
  parameter int W_BAL     = 2,
  parameter int W_BULK    = 4,
  localparam int WIN_W    = $clog2(WIN_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic              take_lat,
  input  logic              take_bulk,
  input  logic [CRED_W-1:0] bal_cred_nx,
  input  logic [CRED_W-1:0] bulk_cred_nx,
  output logic [WIN_W:0]    pri_used,
  output logic [WIN_W:0]    bulk_used,
  output logic [CRED_W-1:0] bal_cred,
  output logic [CRED_W-1:0] bulk_cred
);
  logic [WIN_W-1:0] slot_cnt;
  logic             last_slot;

  assign last_slot = (slot_cnt == WIN_W'(WIN_SLOTS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_cnt  <= '0;
      pri_used  <= '0;
      bulk_used <= '0;
      bal_cred  <= CRED_W'(W_BAL);
      bulk_cred <= CRED_W'(W_BULK);
    end else if (commit) begin
      if (last_slot) begin
        slot_cnt  <= '0;
        pri_used  <= '0;
        bulk_used <= '0;
        bal_cred  <= CRED_W'(W_BAL);
        bulk_cred <= CRED_W'(W_BULK);
      end else begin
        slot_cnt  <= slot_cnt + 1'b1;
        pri_used  <= pri_used  + (WIN_W+1)'(take_lat);
        bulk_used <= bulk_used + (WIN_W+1)'(take_bulk);
        bal_cred  <= bal_cred_nx;
        bulk_cred <= bulk_cred_nx;
      end
    end
  end

  // R9: a start in the final slot clears the window accounting
  p_window_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit && last_slot |=> (pri_used == '0) && (bulk_used == '0));

  // R4: usage can never exceed the starts seen in this window
  p_usage_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_used + bulk_used) <= {1'b0, slot_cnt});
endmodule

// File: rtl/qsched_hold.sv
module qsched_hold #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       pick,
  input  logic [LEN_W-1:0] len_sel,
  input  logic             out_ready,
  output logic [2:0]       grant,
  output logic             commit,
  output logic             busy
);
  logic [2:0]       owner;
  logic [LEN_W-1:0] rem;
  logic [LEN_W-1:0] eff_len;

  assign eff_len = (len_sel == '0) ? LEN_W'(1) : len_sel;
  assign grant   = busy ? owner : pick;
  assign commit  = !busy && (pick != 3'b000) && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      owner <= 3'b000;
      rem   <= '0;
    end else if (commit) begin
      if (eff_len > LEN_W'(1)) begin
        busy  <= 1'b1;
        owner <= pick;
        rem   <= eff_len - 1'b1;
      end
    end else if (busy && out_ready) begin
      rem <= rem - 1'b1;
      if (rem == LEN_W'(1)) busy <= 1'b0;
    end
  end

  // R1: never more than one owner
  p_grant_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R2: back-pressure freezes an ongoing packet
  p_hold_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !out_ready |=> busy && (grant == $past(grant)));

  // R2: a packet in flight cannot lose its owner before its beats are taken
  p_hold_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (rem > LEN_W'(1)) |=> busy && (grant == $past(grant)));
endmodule

// File: rtl/qsched_satcnt.sv
module qsched_satcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (inc && (cnt != '1))  cnt <= cnt + 1'b1;
  end

  // R10: saturated counter stays put
  p_sat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '1) |=> (cnt == '1));

  // R10: each start below saturation adds exactly one
  p_sat_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inc && (cnt != '1) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/qos_class_sched.sv
module qos_class_sched #(
  parameter int LEN_W     = 4,
  parameter int CNT_W     = 16,
  parameter int WIN_SLOTS = 64,
  parameter int W_BAL     = qsched_pkg::DEF_W_BAL,
  parameter int W_BULK    = qsched_pkg::DEF_W_BULK,
  localparam int NCLS     = qsched_pkg::NUM_CLS,
  localparam int WIN_W    = $clog2(WIN_SLOTS),
  localparam int CRED_W   = $clog2(((W_BAL > W_BULK) ? W_BAL : W_BULK) + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCLS-1:0]       req,
  input  logic [NCLS*LEN_W-1:0] len_hint,
  input  logic                  out_ready,
  input  logic [WIN_W:0]        cfg_pri_max,
  input  logic [WIN_W:0]        cfg_bulk_cap,
  output logic [NCLS-1:0]       grant,
  output logic [NCLS*CNT_W-1:0] svc_count
);
  import qsched_pkg::*;

  logic [2:0]        pick;
  logic [CRED_W-1:0] bal_cred, bulk_cred, bal_cred_nx, bulk_cred_nx;
  logic [WIN_W:0]    pri_used, bulk_used;
  logic [LEN_W-1:0]  len_sel;
  logic              commit, busy;

  always_comb begin
    len_sel = '0;
    for (int i = 0; i < NCLS; i++)
      if (pick[i]) len_sel = len_hint[i*LEN_W +: LEN_W];
  end

  qsched_pick #(.WIN_W(WIN_W), .CRED_W(CRED_W), .W_BAL(W_BAL), .W_BULK(W_BULK)) u_pick (
    .req(req), .pri_used(pri_used), .bulk_used(bulk_used),
    .cfg_pri_max(cfg_pri_max), .cfg_bulk_cap(cfg_bulk_cap),
    .bal_cred(bal_cred), .bulk_cred(bulk_cred),
    .pick(pick), .bal_cred_nx(bal_cred_nx), .bulk_cred_nx(bulk_cred_nx)
  );

  qsched_window #(.WIN_SLOTS(WIN_SLOTS), .CRED_W(CRED_W), .W_BAL(W_BAL), .W_BULK(W_BULK)) u_win (
    .clk(clk), .rst_n(rst_n), .commit(commit),
    .take_lat(pick[CLS_LAT]), .take_bulk(pick[CLS_BULK]),
    .bal_cred_nx(bal_cred_nx), .bulk_cred_nx(bulk_cred_nx),
    .pri_used(pri_used), .bulk_used(bulk_used),
    .bal_cred(bal_cred), .bulk_cred(bulk_cred)
  );

  qsched_hold #(.LEN_W(LEN_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .pick(pick), .len_sel(len_sel),
    .out_ready(out_ready), .grant(grant), .commit(commit), .busy(busy)
  );

  for (genvar g = 0; g < NCLS; g++) begin : g_cnt
    qsched_satcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(commit && pick[g]),
      .cnt(svc_count[g*CNT_W +: CNT_W])
    );
  end

  // R1: an idle scheduler only offers to a requesting class
  p_idle_grant_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ((grant & ~req) == 3'b000));

  // R3: a lone requester is always offered the egress
  p_sole_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && ($countones(req) == 1) |-> (grant == req));

  // R4: an eligible latency request beats everything when idle
  p_lat_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && req[CLS_LAT] && (pri_used < cfg_pri_max) |-> grant[CLS_LAT]);
endmodule

// File: tb/tb_qos_class_sched.sv
module tb_qos_class_sched;
  localparam int LEN_W = 4;
  localparam int CNT_W = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [2:0]         req = '0;
  logic [3*LEN_W-1:0] len_hint = {4'd1, 4'd1, 4'd1};
  logic               out_ready = 1'b1;
  logic [6:0]         cfg_pri_max = 7'd32;
  logic [6:0]         cfg_bulk_cap = 7'd64;
  logic [2:0]         grant;
  logic [3*CNT_W-1:0] svc_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  qos_class_sched #(.LEN_W(LEN_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .len_hint(len_hint),
    .out_ready(out_ready), .cfg_pri_max(cfg_pri_max),
    .cfg_bulk_cap(cfg_bulk_cap), .grant(grant), .svc_count(svc_count)
  );

  // {req, expected grant}, single-beat packets, pri cap 32, bulk cap 64
  localparam logic [5:0] VEC [0:15] = '{
    {3'b000, 3'b000}, {3'b001, 3'b001}, {3'b111, 3'b001}, {3'b110, 3'b010},
    {3'b110, 3'b010}, {3'b110, 3'b100}, {3'b110, 3'b100}, {3'b110, 3'b100},
    {3'b110, 3'b100}, {3'b110, 3'b010}, {3'b011, 3'b001}, {3'b100, 3'b100},
    {3'b010, 3'b010}, {3'b110, 3'b010}, {3'b110, 3'b100}, {3'b101, 3'b001}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [6:0] pmax, input logic [6:0] bcap);
    rst_n = 1'b0;
    req = '0;
    out_ready = 1'b1;
    len_hint = {4'd1, 4'd1, 4'd1};
    cfg_pri_max = pmax;
    cfg_bulk_cap = bcap;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive at the falling edge, check the grant before the next rising edge
  task automatic step(input logic [2:0] r, input logic rdy, input logic [2:0] exp, input string tag);
    @(negedge clk);
    req = r;
    out_ready = rdy;
    #1;
    chk(tag, grant, exp);
  endtask

  task automatic idle_counts(input int lat, input int bal, input int bulk, input string tag);
    @(negedge clk);
    req = '0;
    #1;
    chk({tag, " lat count"},  svc_count[0 +: CNT_W],       lat);
    chk({tag, " bal count"},  svc_count[CNT_W +: CNT_W],   bal);
    chk({tag, " bulk count"}, svc_count[2*CNT_W +: CNT_W], bulk);
  endtask

  initial begin
    // R11 reset state
    do_reset(7'd32, 7'd64);
    idle_counts(0, 0, 0, "R11 reset");
    chk("R11 idle grant", grant, 0);

    // R1 R4 R6 vector table
    for (int i = 0; i < 16; i++)
      step(VEC[i][5:3], 1'b1, VEC[i][2:0], "R1/R4/R6 table");
    idle_counts(4, 5, 6, "R10 table");

    // R5 and R9: latency cap 4, window rollover
    do_reset(7'd4, 7'd64);
    for (int i = 0; i < 64; i++)
      step(3'b011, 1'b1, (i < 4) ? 3'b001 : 3'b010, "R5 capped latency");
    step(3'b011, 1'b1, 3'b001, "R9 window restart");

    // R3: lone requesters ignore zero caps
    do_reset(7'd0, 7'd0);
    step(3'b001, 1'b1, 3'b001, "R3 lone latency");
    step(3'b100, 1'b1, 3'b100, "R3 lone bulk");
    // R8: both requesters over cap -> latency
    step(3'b101, 1'b1, 3'b001, "R8 fallback");
    step(3'b101, 1'b1, 3'b001, "R8 fallback again");
    step(3'b011, 1'b1, 3'b010, "R5 latency at zero cap");

    // R7: bulk cap 2
    do_reset(7'd32, 7'd2);
    step(3'b110, 1'b1, 3'b010, "R7 bal");
    step(3'b110, 1'b1, 3'b010, "R7 bal");
    step(3'b110, 1'b1, 3'b100, "R7 bulk 1");
    step(3'b110, 1'b1, 3'b100, "R7 bulk 2");
    step(3'b110, 1'b1, 3'b010, "R7 bulk capped");
    step(3'b110, 1'b1, 3'b010, "R7 bulk still capped");

    // R2: multi-beat hold with back-pressure, then zero length
    do_reset(7'd32, 7'd64);
    len_hint = {4'd1, 4'd1, 4'd3};
    step(3'b011, 1'b1, 3'b001, "R2 beat 1");
    step(3'b011, 1'b0, 3'b001, "R2 stalled");
    step(3'b011, 1'b1, 3'b001, "R2 beat 2");
    step(3'b011, 1'b1, 3'b001, "R2 beat 3");
    step(3'b010, 1'b1, 3'b010, "R2 after packet");
    idle_counts(1, 1, 0, "R2 one start per packet");
    step(3'b010, 1'b0, 3'b010, "R2 offer without ready");
    idle_counts(1, 1, 0, "R2 no start without ready");
    len_hint = {4'd1, 4'd1, 4'd0};
    step(3'b001, 1'b1, 3'b001, "R2 zero length");
    step(3'b010, 1'b1, 3'b010, "R2 zero length is one beat");
    idle_counts(2, 2, 0, "R10 after R2");

    // R10 saturation
    do_reset(7'd32, 7'd64);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      req = 3'b100;
    end
    idle_counts(0, 0, 255, "R10 saturation");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule